// File: doc/BRIEF.md
# Cartridge Bank Translation Unit

This block sits between a console CPU, its video chip and the cartridge ROMs. It holds a set of programmable bank registers and uses them to turn the narrow addresses that the CPU and the video chip produce into wide physical ROM addresses. The CPU program window covers 32 KB and is cut into four 8 KB slots. The video character window covers 8 KB and is cut into eight 1 KB slots. Each slot is mapped to whichever ROM bank its register names. The block also holds a two-bit nametable mirroring mode for the video memory wiring.

Software programs the block through a register-write port. A write has an address, an 8-bit data byte and a strobe, and only the low 11 address bits are decoded. The block can be built for a cartridge whose character space is RAM rather than ROM. In that case, video addresses reach the RAM unchanged and video writes are passed through.

Translation is purely combinational from the stored registers. A register write takes effect on the clock edge that captures it.

Top module: `bank_xlate_unit`

## Requirements
- R1: After reset, the PRG bank registers for slots 0 to 3 hold 0x00, 0x01, 0xFE and 0xFF, each ANDed with PRG_BANKS-1. All eight CHR bank registers hold 0. The mirroring code holds MIRROR_INIT, which defaults to 2.
- R2: A write whose low 11 address bits are 0x504 + i (i = 0..3) stores the data byte, ANDed with PRG_BANKS-1, in PRG slot register i. The new value is visible from the next rising clock edge.
- R3: prg_addr is combinationally {PRG slot register[cpu_addr[14:13]], cpu_addr[12:0]}.
- R4: A write whose low 11 address bits are 0x510 + j (j = 0..7) stores the data byte, ANDed with CHR_BANKS-1, in CHR slot register j. The new value is visible from the next rising clock edge.
- R5: With CHR_RAM = 0, chr_addr is combinationally {CHR slot register[vid_addr[12:10]], vid_addr[9:0]}.
- R6: A write whose low 11 address bits are 0x2FE or 0x2FF sets mirror_mode to {reg_addr[0], reg_wdata[4]} on the next edge. The codes are 0 = single-screen A, 1 = single-screen B, 2 = vertical and 3 = horizontal.
- R7: reg_addr bits 15:11 play no part in decoding, so a write at 0xFD05 acts exactly like a write at 0x505.
- R8: A write to any other offset, including 0x500 to 0x503, 0x508, 0x518 and 0x2FD, leaves every bank register and the mirroring code unchanged.
- R9: With CHR_RAM = 1, chr_addr is vid_addr zero-extended and chr_we follows vid_we. With CHR_RAM = 0, chr_we is always 0.
- R10: While reg_we is low, no register changes, whatever reg_addr and reg_wdata hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register write address (bits 10:0 decoded) |
| reg_wdata | input | 8 | Register write data |
| cpu_addr | input | 15 | CPU offset inside the 32 KB program window |
| prg_addr | output | PRG_BW+13 | Physical PRG ROM address |
| vid_addr | input | 13 | Video character-space address |
| vid_we | input | 1 | Video write request to character space |
| chr_addr | output | CHR_BW+10 | Physical CHR address |
| chr_we | output | 1 | Write enable to character RAM |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
The two translated addresses have no register on their path. The bench sets cpu_addr or vid_addr just after a falling edge and compares one nanosecond later, in the same cycle.

A register write is driven at a falling edge and captured at the next rising edge. The bench lowers the strobe at the following falling edge and only then reads the new bank or mirroring state, which is one full cycle after the write was presented.

The bench runs checks on "no effect" stimulus (unmatched offsets and a dropped strobe) at that same point. The checker compares register contents with the write seen one edge earlier.

// File: rtl/bxu_pkg.sv
package bxu_pkg;

    typedef enum logic [1:0] {
        WK_NONE   = 2'd0,
        WK_MIRROR = 2'd1,
        WK_PRG    = 2'd2,
        WK_CHR    = 2'd3
    } wr_kind_e;

    typedef enum logic [1:0] {
        MIR_SINGLE_A = 2'd0,
        MIR_SINGLE_B = 2'd1,
        MIR_VERT     = 2'd2,
        MIR_HORIZ    = 2'd3
    } mirror_e;

    localparam logic [10:0] OFS_MIRROR = 11'h2FE;
    localparam logic [10:0] OFS_PRG    = 11'h504;
    localparam logic [10:0] OFS_CHR    = 11'h510;

    localparam int PRG_SLOTS = 4;
    localparam int CHR_SLOTS = 8;

    function automatic logic [7:0] prg_reset_bank(input int slot);
        case (slot)
            0:       return 8'h00;
            1:       return 8'h01;
            2:       return 8'hFE;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/bxu_wr_decode.sv
module bxu_wr_decode
    import bxu_pkg::*;
(
    input  logic        reg_we,
    input  logic [15:0] reg_addr,
    output wr_kind_e    wr_kind,
    output logic [2:0]  wr_idx
);

    logic [10:0] ofs;

    assign ofs    = reg_addr[10:0];
    assign wr_idx = ofs[2:0];

    always_comb begin
        wr_kind = WK_NONE;
        if (reg_we) begin
            if (ofs[10:1] == OFS_MIRROR[10:1]) begin
                wr_kind = WK_MIRROR;
            end else if (ofs[10:2] == OFS_PRG[10:2]) begin
                wr_kind = WK_PRG;
            end else if (ofs[10:3] == OFS_CHR[10:3]) begin
                wr_kind = WK_CHR;
            end
        end
    end

endmodule

// File: rtl/bxu_bank_regs.sv
module bxu_bank_regs
    import bxu_pkg::*;
#(
    parameter int         PRG_BW      = 5,
    parameter int         CHR_BW      = 7,
    parameter logic [1:0] MIRROR_INIT = 2'd2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  wr_kind_e                    wr_kind,
    input  logic [2:0]                  wr_idx,
    input  logic                        wr_addr0,
    input  logic [7:0]                  wr_data,
    output logic [PRG_SLOTS*PRG_BW-1:0] prg_flat,
    output logic [CHR_SLOTS*CHR_BW-1:0] chr_flat,
    output mirror_e                     mirror_q
);

    for (genvar g = 0; g < PRG_SLOTS; g++) begin : g_prg
        localparam logic [7:0] INIT_V = prg_reset_bank(g);
        logic [PRG_BW-1:0] bank_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q <= INIT_V[PRG_BW-1:0];
            end else if (wr_kind == WK_PRG && wr_idx[1:0] == 2'(g)) begin
                bank_q <= wr_data[PRG_BW-1:0];
            end
        end

        assign prg_flat[g*PRG_BW +: PRG_BW] = bank_q;
    end

    for (genvar g = 0; g < CHR_SLOTS; g++) begin : g_chr
        logic [CHR_BW-1:0] bank_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q <= '0;
            end else if (wr_kind == WK_CHR && wr_idx == 3'(g)) begin
                bank_q <= wr_data[CHR_BW-1:0];
            end
        end

        assign chr_flat[g*CHR_BW +: CHR_BW] = bank_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mirror_q <= mirror_e'(MIRROR_INIT);
        end else if (wr_kind == WK_MIRROR) begin
            mirror_q <= mirror_e'({wr_addr0, wr_data[4]});
        end
    end

endmodule

// File: rtl/bxu_slot_map.sv
module bxu_slot_map #(
    parameter int NREG       = 4,
    parameter int SEL_W      = 2,
    parameter int OFF_W      = 13,
    parameter int BANK_BW    = 5,
    parameter bit RAM_BYPASS = 1'b0,
    localparam int IN_W      = SEL_W + OFF_W,
    localparam int OUT_W     = BANK_BW + OFF_W
) (
    input  logic [NREG*BANK_BW-1:0] bank_flat,
    input  logic [IN_W-1:0]         win_addr,
    output logic [OUT_W-1:0]        phys_addr
);

    if (RAM_BYPASS) begin : g_bypass
        always_comb begin
            phys_addr = '0;
            phys_addr[IN_W-1:0] = win_addr;
        end
    end else begin : g_banked
        logic [SEL_W-1:0]   sel;
        logic [BANK_BW-1:0] bank;

        always_comb begin
            sel       = win_addr[IN_W-1:OFF_W];
            bank      = bank_flat[int'(sel)*BANK_BW +: BANK_BW];
            phys_addr = {bank, win_addr[OFF_W-1:0]};
        end
    end

endmodule

// File: rtl/bank_xlate_unit.sv
module bank_xlate_unit
    import bxu_pkg::*;
#(
    parameter int         PRG_BANKS   = 32,
    parameter int         CHR_BANKS   = 128,
    parameter bit         CHR_RAM     = 1'b0,
    parameter logic [1:0] MIRROR_INIT = 2'd2,
    localparam int        PRG_BW      = $clog2(PRG_BANKS),
    localparam int        CHR_BW      = $clog2(CHR_BANKS),
    localparam int        PRG_AW      = PRG_BW + 13,
    localparam int        CHR_AW      = CHR_BW + 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [15:0]       reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic [14:0]       cpu_addr,
    output logic [PRG_AW-1:0] prg_addr,
    input  logic [12:0]       vid_addr,
    input  logic              vid_we,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              chr_we,
    output logic [1:0]        mirror_mode
);

    wr_kind_e                    wr_kind;
    logic [2:0]                  wr_idx;
    logic [PRG_SLOTS*PRG_BW-1:0] prg_flat;
    logic [CHR_SLOTS*CHR_BW-1:0] chr_flat;
    mirror_e                     mirror_q;

    bxu_wr_decode dec_i (
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .wr_kind  (wr_kind),
        .wr_idx   (wr_idx)
    );

    bxu_bank_regs #(
        .PRG_BW      (PRG_BW),
        .CHR_BW      (CHR_BW),
        .MIRROR_INIT (MIRROR_INIT)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_kind  (wr_kind),
        .wr_idx   (wr_idx),
        .wr_addr0 (reg_addr[0]),
        .wr_data  (reg_wdata),
        .prg_flat (prg_flat),
        .chr_flat (chr_flat),
        .mirror_q (mirror_q)
    );

    bxu_slot_map #(
        .NREG       (PRG_SLOTS),
        .SEL_W      (2),
        .OFF_W      (13),
        .BANK_BW    (PRG_BW),
        .RAM_BYPASS (1'b0)
    ) prg_map_i (
        .bank_flat (prg_flat),
        .win_addr  (cpu_addr),
        .phys_addr (prg_addr)
    );

    bxu_slot_map #(
        .NREG       (CHR_SLOTS),
        .SEL_W      (3),
        .OFF_W      (10),
        .BANK_BW    (CHR_BW),
        .RAM_BYPASS (CHR_RAM)
    ) chr_map_i (
        .bank_flat (chr_flat),
        .win_addr  (vid_addr),
        .phys_addr (chr_addr)
    );

    assign chr_we      = CHR_RAM && vid_we;
    assign mirror_mode = mirror_q;

endmodule

// File: rtl/bxu_checker.sv
module bxu_checker #(
    parameter int PRG_BW  = 5,
    parameter int CHR_BW  = 7,
    parameter int CHR_AW  = 17,
    parameter bit CHR_RAM = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [15:0]       reg_addr,
    input logic [7:0]        reg_wdata,
    input logic [4*PRG_BW-1:0] prg_flat,
    input logic [8*CHR_BW-1:0] chr_flat,
    input logic [1:0]        mirror_mode,
    input logic [12:0]       vid_addr,
    input logic [CHR_AW-1:0] chr_addr
);

    logic unmapped_wr;
    assign unmapped_wr = reg_we && (reg_addr[10:0] == 11'h501 || reg_addr[10:0] == 11'h502 ||
                                    reg_addr[10:0] == 11'h503 || reg_addr[10:0] == 11'h508 ||
                                    reg_addr[10:0] == 11'h518 || reg_addr[10:0] == 11'h2FD);

    assert_reset_layout_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (prg_flat[PRG_BW-1:0] == '0) && (prg_flat[3*PRG_BW +: PRG_BW] == '1)
                          && (chr_flat == '0));

    assert_prg_slot3_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr[10:0] == 11'h507 |=> prg_flat[3*PRG_BW +: PRG_BW] == $past(reg_wdata[PRG_BW-1:0]));

    assert_chr_slot0_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr[10:0] == 11'h510 |=> chr_flat[CHR_BW-1:0] == $past(reg_wdata[CHR_BW-1:0]));

    assert_mirror_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr[10:1] == 10'h17F |=> mirror_mode == {$past(reg_addr[0]), $past(reg_wdata[4])});

    assert_unmapped_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_wr |=> $stable(prg_flat) && $stable(chr_flat) && $stable(mirror_mode));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(prg_flat) && $stable(chr_flat) && $stable(mirror_mode));

    if (CHR_RAM) begin : g_ram_chk
        assert_ram_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
            chr_addr == CHR_AW'(vid_addr));
    end

endmodule

bind bank_xlate_unit bxu_checker #(
    .PRG_BW  (PRG_BW),
    .CHR_BW  (CHR_BW),
    .CHR_AW  (CHR_AW),
    .CHR_RAM (CHR_RAM)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .prg_flat    (prg_flat),
    .chr_flat    (chr_flat),
    .mirror_mode (mirror_mode),
    .vid_addr    (vid_addr),
    .chr_addr    (chr_addr)
);

// File: tb/bank_xlate_unit_tb_top.sv
`timescale 1ns/1ps
module bank_xlate_unit_tb_top;

    localparam int PRG_BANKS = 32;
    localparam int CHR_BANKS = 128;
    localparam int PRG_AW    = 18;
    localparam int CHR_AW    = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [15:0]       reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic [14:0]       cpu_addr = '0;
    logic [12:0]       vid_addr = '0;
    logic              vid_we = 1'b0;
    logic [PRG_AW-1:0] prg_addr, prg_addr_r;
    logic [CHR_AW-1:0] chr_addr, chr_addr_r;
    logic              chr_we, chr_we_r;
    logic [1:0]        mirror_mode, mirror_mode_r;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [7:0] prg_m [4];
    logic [7:0] chr_m [8];
    logic [1:0] mir_m;

    always #4 clk = ~clk;

    bank_xlate_unit #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS), .CHR_RAM(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .cpu_addr(cpu_addr), .prg_addr(prg_addr), .vid_addr(vid_addr), .vid_we(vid_we),
        .chr_addr(chr_addr), .chr_we(chr_we), .mirror_mode(mirror_mode));

    bank_xlate_unit #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS), .CHR_RAM(1'b1)) dut_ram_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .cpu_addr(cpu_addr), .prg_addr(prg_addr_r), .vid_addr(vid_addr), .vid_we(vid_we),
        .chr_addr(chr_addr_r), .chr_we(chr_we_r), .mirror_mode(mirror_mode_r));

    function automatic logic [PRG_AW-1:0] exp_prg(input logic [14:0] a);
        logic [7:0] b;
        b = prg_m[a[14:13]] & 8'(PRG_BANKS - 1);
        return {b[4:0], a[12:0]};
    endfunction

    function automatic logic [CHR_AW-1:0] exp_chr(input logic [12:0] a);
        logic [7:0] b;
        b = chr_m[a[12:10]] & 8'(CHR_BANKS - 1);
        return {b[6:0], a[9:0]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        logic [10:0] o;
        o = a[10:0];
        if (o[10:1] == 10'h17F)      mir_m = {o[0], d[4]};
        else if (o[10:2] == 9'h141)  prg_m[o[1:0]] = d;
        else if (o[10:3] == 8'hA2)   chr_m[o[2:0]] = d;
    endtask

    task automatic write_reg(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic check_state(input string req);
        for (int s = 0; s < 4; s++) begin
            cpu_addr = {2'(s), 13'($urandom)};
            #1;
            check(prg_addr == exp_prg(cpu_addr), req, int'(prg_addr), int'(exp_prg(cpu_addr)));
        end
        for (int s = 0; s < 8; s++) begin
            vid_addr = {3'(s), 10'($urandom)};
            #1;
            check(chr_addr == exp_chr(vid_addr), req, int'(chr_addr), int'(exp_chr(vid_addr)));
        end
        check(mirror_mode == mir_m, req, int'(mirror_mode), int'(mir_m));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        prg_m[0] = 8'h00; prg_m[1] = 8'h01; prg_m[2] = 8'hFE; prg_m[3] = 8'hFF;
        for (int i = 0; i < 8; i++) chr_m[i] = 8'h00;
        mir_m = 2'd2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset layout, R3/R5 translation through it
        check_state("R1");

        // R2, R3: PRG writes, one value above the mask
        write_reg(16'h0504, 8'h03);
        write_reg(16'h0505, 8'hE5);
        write_reg(16'h0506, 8'h11);
        write_reg(16'h0507, 8'h1F);
        check_state("R2");
        cpu_addr = 15'h2ABC; #1;
        check(prg_addr == {5'h05, 13'h0ABC}, "R3", int'(prg_addr), int'({5'h05, 13'h0ABC}));

        // R4, R5: CHR writes including masked value
        for (int j = 0; j < 8; j++) write_reg(16'h0510 + 16'(j), 8'(8'h80 + 8'(j * 9)));
        check_state("R4");
        vid_addr = 13'h0C21; #1;
        check(chr_addr == {7'h1B, 10'h021}, "R5", int'(chr_addr), int'({7'h1B, 10'h021}));

        // R7: upper address bits ignored
        write_reg(16'hFD05, 8'h0A);
        check_state("R7");
        cpu_addr = 15'h2000; #1;
        check(prg_addr == {5'h0A, 13'h0}, "R7", int'(prg_addr), int'({5'h0A, 13'h0}));

        // R6: all four mirroring codes
        write_reg(16'h02FE, 8'h00); check(mirror_mode == 2'd0, "R6", int'(mirror_mode), 0);
        write_reg(16'h02FE, 8'h10); check(mirror_mode == 2'd1, "R6", int'(mirror_mode), 1);
        write_reg(16'h02FF, 8'hEF); check(mirror_mode == 2'd2, "R6", int'(mirror_mode), 2);
        write_reg(16'h02FF, 8'h10); check(mirror_mode == 2'd3, "R6", int'(mirror_mode), 3);

        // R8: unmatched offsets have no effect
        write_reg(16'h0500, 8'hFF); write_reg(16'h0501, 8'h01);
        write_reg(16'h0502, 8'h77); write_reg(16'h0503, 8'h55);
        write_reg(16'h0508, 8'h13); write_reg(16'h0518, 8'h21);
        write_reg(16'h02FD, 8'h00); write_reg(16'h050F, 8'h04);
        check_state("R8");

        // R10: strobe low, matching address held for several cycles
        @(negedge clk);
        reg_addr = 16'h0504; reg_wdata = 8'h1C; reg_we = 1'b0;
        repeat (3) @(negedge clk);
        reg_addr = 16'h02FE; reg_wdata = 8'h00;
        repeat (2) @(negedge clk);
        check_state("R10");

        // R9: RAM variant and ROM variant write-enable behaviour
        for (int k = 0; k < 20; k++) begin
            vid_addr = 13'($urandom);
            vid_we   = 1'($urandom);
            #1;
            check(chr_addr_r == CHR_AW'(vid_addr), "R9", int'(chr_addr_r), int'(vid_addr));
            check(chr_we_r == vid_we, "R9", int'(chr_we_r), int'(vid_we));
            check(chr_we == 1'b0, "R9", int'(chr_we), 0);
        end
        vid_we = 1'b0;

        // Random mix of writes across all classes
        for (int n = 0; n < 300; n++) begin
            logic [15:0] a;
            case ($urandom_range(0, 4))
                0: a = {5'($urandom), 11'h504 + 11'($urandom_range(0, 3))};
                1: a = {5'($urandom), 11'h510 + 11'($urandom_range(0, 7))};
                2: a = {5'($urandom), 11'h2FE + 11'($urandom_range(0, 1))};
                default: a = 16'($urandom);
            endcase
            write_reg(a, 8'($urandom));
            if (n % 10 == 0) check_state("R2 R4 R6 R8 random");
            else begin
                cpu_addr = 15'($urandom); vid_addr = 13'($urandom); #1;
                check(prg_addr == exp_prg(cpu_addr), "R3", int'(prg_addr), int'(exp_prg(cpu_addr)));
                check(chr_addr == exp_chr(vid_addr), "R5", int'(chr_addr), int'(exp_chr(vid_addr)));
                check(mirror_mode == mir_m, "R6", int'(mirror_mode), int'(mir_m));
            end
        end

        finish_run();
    end

endmodule